// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is a byte-wide synchronous serial port. One shift clock serves both directions. A CPU-side register interface holds the transmit byte, the control bits and the status. The port then moves the byte out on a data line, least significant bit first, and takes a byte in on a second line during the same eight clock cycles. As master, the port makes the shift clock from a divider of the system clock. As slave, it follows a clock from an external master and raises a ready line to tell that master a byte is waiting.

Transmit and receive are tied together on purpose. The clock generator belongs to the transmit side, so a transfer starts only while transmit is enabled. Once a transfer has started, clearing the transmit enable alone does not stop it, and clearing the port enable alone only parks the pins. Only clearing transmit enable and receive enable together resets the shift registers and the bit counter. The transmit-complete flag drops only after the write has been synchronized to the shift clock, which takes between half a shift period and one and a half shift periods.

Top module: `ssio_port`

## Requirements
- R1: After reset, `txd_o` and `sclk_o` are 1 and `srdy_o` is 0. The status word (address 2) reads 1 in bit 0 (transmit complete), 0 in bit 1 (receive full) and 0 in bit 2 (transmit byte pending).
- R2: The control word sits at address 1. Its bits are: bit 0 transmit enable, bit 1 receive enable, bit 2 ready-line enable, bit 3 port enable, bit 4 external clock. In master mode a shift period is 2*DIV_HALF system clocks. `txd_o` changes on the falling shift edge, least significant bit first. `rxd_i` is sampled on the rising shift edge. Eight shift clocks make one byte.
- R3: After the eighth rising edge, the received byte is readable at address 0. Receive full is then set, but only if receive enable is 1. A read of address 0 clears receive full. With receive enable at 0, the receive buffer and flag are left untouched.
- R4: A write to address 0 sets the pending bit. In master mode, transmit complete then falls no sooner than half a shift period and no later than one and a half shift periods after the write. It stays 0 while a transfer is running.
- R5: If a byte is pending when a transfer ends, the next byte starts on the next falling edge, and transmit complete stays 0 across the join. Otherwise transmit complete returns to 1 and `sclk_o` idles at 1.
- R6: With transmit enable at 0, a pending byte produces no shift clock and no transfer. The transfer starts once transmit enable is set.
- R7: Clearing transmit enable alone during a transfer does not stop it. All eight bits are still shifted and received.
- R8: Clearing port enable alone holds `txd_o` and `sclk_o` at 1 but does not reset the transfer. The transfer completes with its received byte.
- R9: Once transmit enable and receive enable are both 0, the transfer is abandoned within one clock. The bit counter and shift registers are cleared, the pending byte is dropped and transmit complete reads 1. The next transfer after re-enabling is whole.
- R10: `srdy_o` is 1 exactly when port enable, ready-line enable, transmit enable and receive enable are all 1, a byte is pending, and no transfer is running. It falls at the first falling edge of a transfer.
- R11: With external clock, the shift edges come from `sclk_i` after synchronization. A transfer is armed only while `sclk_i` is high and starts on its next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe (clears receive full when address is 0) |
| rd_addr | input | 2 | Read address: 0 receive buffer, 1 control, 2 status |
| rd_data | output | DATA_W | Combinational read data |
| sclk_i | input | 1 | Shift clock from an external master |
| sclk_o | output | 1 | Shift clock driven in master mode |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| srdy_o | output | 1 | Ready indication to an external master |

## Verification
Some properties are checked on every cycle: shift edges never coincide, a transfer begins only on a falling edge, receive full rises only on a rising edge, transmit complete is low throughout a transfer, a running transfer survives anything short of both enables clearing, and clearing both enables stops it at once. Other behaviour only the bench scenarios can show: the delay from write to flag drop measured at each divider phase, bit order and data integrity over all 256 byte values in loopback, the back-to-back join, the ready-line gating, and slave-mode shifting driven by an external clock.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
   typedef struct packed {
      logic ext_clk;
      logic port_en;
      logic rdy_en;
      logic rx_en;
      logic tx_en;
   } ssio_ctrl_t;

   localparam int unsigned CTRL_W = $bits(ssio_ctrl_t);

   localparam logic [1:0] ADR_DATA = 2'd0;
   localparam logic [1:0] ADR_CTRL = 2'd1;
   localparam logic [1:0] ADR_STAT = 2'd2;
endpackage

// File: rtl/ssio_clkgen.sv
module ssio_clkgen #(
   parameter int unsigned DIV_HALF    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_CLK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ext_mode,
   input  logic sclk_i,
   output logic fall_ev,
   output logic rise_ev,
   output logic arm_ev,
   output logic int_level
);
   localparam int unsigned CW = $clog2(DIV_HALF + 1);
   localparam logic [CW-1:0] DIV_LAST = CW'(DIV_HALF - 1);

   initial begin
      assert (DIV_HALF >= 2) else $error("DIV_HALF must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [CW-1:0] div_q;
   logic          ph_q;
   logic          tick;

   assign tick = run && (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         ph_q  <= 1'b1;
      end else if (!run) begin
         div_q <= '0;
         ph_q  <= 1'b1;
      end else if (tick) begin
         div_q <= '0;
         ph_q  <= ~ph_q;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   logic int_fall, int_rise;
   assign int_fall  = tick & ph_q;
   assign int_rise  = tick & ~ph_q;
   assign int_level = ph_q;

   logic ext_fall, ext_rise, ext_level, use_ext;

   generate
      if (EXT_CLK_EN) begin : g_ext
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
               prev_q <= 1'b1;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
               prev_q <= sync_q[SYNC_STAGES-1];
            end
         end
         assign ext_level = sync_q[SYNC_STAGES-1];
         assign ext_fall  = prev_q & ~ext_level;
         assign ext_rise  = ~prev_q & ext_level;
         assign use_ext   = ext_mode;
      end else begin : g_noext
         assign ext_level = 1'b1;
         assign ext_fall  = 1'b0;
         assign ext_rise  = 1'b0;
         assign use_ext   = 1'b0;
      end
   endgenerate

   assign fall_ev = use_ext ? ext_fall : int_fall;
   assign rise_ev = use_ext ? ext_rise : int_rise;
   assign arm_ev  = use_ext ? ext_level : int_rise;

   a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_ev, rise_ev}));
endmodule

// File: rtl/ssio_shifter.sv
module ssio_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              wr_tx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_rx,
   input  logic              fall_ev,
   input  logic              rise_ev,
   input  logic              arm_ev,
   input  logic              rxd,
   output logic              tx_bit,
   output logic              busy,
   output logic              done,
   output logic              pending,
   output logic              rx_full,
   output logic [DATA_W-1:0] rx_buf
);
   localparam int unsigned CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] tx_buf_q, tx_sh_q, rx_sh_q, rx_buf_q, rx_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q, done_q, pend_q, armed_q, rxf_q;
   logic              start, last_rise;

   assign rx_next   = {rxd, rx_sh_q[DATA_W-1:1]};
   assign start     = fall_ev & ~busy_q & armed_q & pend_q & tx_en;
   assign last_rise = rise_ev & busy_q & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf_q <= '0;
         tx_sh_q  <= '1;
         rx_sh_q  <= '0;
         rx_buf_q <= '0;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b1;
         pend_q   <= 1'b0;
         armed_q  <= 1'b0;
         rxf_q    <= 1'b0;
      end else if (clr) begin
         tx_sh_q  <= '1;
         rx_sh_q  <= '0;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b1;
         pend_q   <= 1'b0;
         armed_q  <= 1'b0;
         if (rd_rx) rxf_q <= 1'b0;
      end else begin
         if (wr_tx) begin
            tx_buf_q <= wr_data;
            pend_q   <= 1'b1;
         end
         if (arm_ev) armed_q <= pend_q & tx_en;
         if (start) begin
            busy_q  <= 1'b1;
            tx_sh_q <= tx_buf_q;
            pend_q  <= wr_tx;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            armed_q <= 1'b0;
         end else if (fall_ev && busy_q) begin
            tx_sh_q <= {1'b1, tx_sh_q[DATA_W-1:1]};
         end
         if (rise_ev && busy_q) begin
            rx_sh_q <= rx_next;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
               done_q <= ~(pend_q & tx_en);
               if (rx_en) rx_buf_q <= rx_next;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (last_rise && rx_en) rxf_q <= 1'b1;
         else if (rd_rx)        rxf_q <= 1'b0;
      end
   end

   assign tx_bit  = busy_q ? tx_sh_q[0] : 1'b1;
   assign busy    = busy_q;
   assign done    = done_q;
   assign pending = pend_q;
   assign rx_full = rxf_q;
   assign rx_buf  = rx_buf_q;

   // R4: flag is low for the whole transfer
   a_r4_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !done_q);
   // R11: a transfer begins only on a falling shift edge
   a_r11_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(fall_ev));
   // R3: receive full rises only on a rising shift edge
   a_r3_full_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxf_q) |-> $past(rise_ev));
   // R7, R8: only the last rising edge or a double disable ends a transfer
   a_r7_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !clr && !last_rise) |=> busy_q);
   // R9: clearing both enables abandons the transfer
   a_r9_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!busy_q && done_q && !pend_q));
endmodule

// File: rtl/ssio_port.sv
module ssio_port
   import ssio_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_HALF    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_CLK_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              txd_o,
   input  logic              rxd_i,
   output logic              srdy_o
);
   initial begin
      assert (DATA_W >= CTRL_W) else $error("DATA_W must hold the control word");
   end

   ssio_ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ctrl_q <= '0;
      else if (wr_en && wr_addr == ADR_CTRL)   ctrl_q <= ssio_ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   logic clr, busy, done, pending, rx_full, tx_bit;
   logic fall_ev, rise_ev, arm_ev, int_level;
   logic [DATA_W-1:0] rx_buf;

   assign clr = ~ctrl_q.tx_en & ~ctrl_q.rx_en;

   ssio_clkgen #(
      .DIV_HALF   (DIV_HALF),
      .SYNC_STAGES(SYNC_STAGES),
      .EXT_CLK_EN (EXT_CLK_EN)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q.tx_en | busy),
      .ext_mode (ctrl_q.ext_clk),
      .sclk_i   (sclk_i),
      .fall_ev  (fall_ev),
      .rise_ev  (rise_ev),
      .arm_ev   (arm_ev),
      .int_level(int_level)
   );

   ssio_shifter #(.DATA_W(DATA_W)) u_shifter (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .tx_en  (ctrl_q.tx_en),
      .rx_en  (ctrl_q.rx_en),
      .wr_tx  (wr_en && wr_addr == ADR_DATA),
      .wr_data(wr_data),
      .rd_rx  (rd_en && rd_addr == ADR_DATA),
      .fall_ev(fall_ev),
      .rise_ev(rise_ev),
      .arm_ev (arm_ev),
      .rxd    (rxd_i),
      .tx_bit (tx_bit),
      .busy   (busy),
      .done   (done),
      .pending(pending),
      .rx_full(rx_full),
      .rx_buf (rx_buf)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADR_DATA: rd_data = rx_buf;
         ADR_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
         ADR_STAT: rd_data[2:0] = {pending, rx_full, done};
         default:  rd_data = '0;
      endcase
   end

   assign sclk_o = (ctrl_q.port_en && !ctrl_q.ext_clk && busy) ? int_level : 1'b1;
   assign txd_o  = ctrl_q.port_en ? tx_bit : 1'b1;
   assign srdy_o = ctrl_q.port_en & ctrl_q.rdy_en & ctrl_q.tx_en & ctrl_q.rx_en
                   & pending & ~busy;

   // R8: pins park high while the port is disabled
   a_r8_pins_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.port_en |-> (sclk_o && txd_o));
   // R10: ready line is low on the cycle after a transfer starts
   a_r10_srdy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !srdy_o);
endmodule

// File: tb/ssio_port_tb.sv
module ssio_port_tb;
   localparam int DW = 8;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic sclk_i = 1'b1, sclk_o, txd_o, srdy_o;
   logic loop = 1'b1, b_rxd = 1'b0, rxd_i;

   assign rxd_i = loop ? txd_o : b_rxd;

   always #2.5 clk = ~clk;

   ssio_port #(.DATA_W(DW), .DIV_HALF(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sclk_i(sclk_i),
      .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i), .srdy_o(srdy_o));

   int n_vec = 0, n_bad = 0, falls = 0;
   bit finished = 1'b0;

   always @(negedge sclk_o) falls++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk); rd_addr = a; #1 d = rd_data;
      if (a == 2'd0) begin rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; end
   endtask

   task automatic wait_done(logic v, int maxc, output int cyc);
      cyc = 0;
      rd_addr = 2'd2;
      do begin @(negedge clk); cyc++; end while (rd_data[0] !== v && cyc < maxc);
   endtask

   task automatic xfer(logic [DW-1:0] v, output logic [DW-1:0] got);
      int c;
      wr(2'd0, v);
      wait_done(1'b0, 40, c);
      wait_done(1'b1, 400, c);
      rd(2'd0, got);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d, got;
      int c, f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 txd", txd_o, 1); chk("R1 sclk", sclk_o, 1); chk("R1 srdy", srdy_o, 0);
      rd(2'd2, d); chk("R1 status", d, 8'h01);

      // R2/R3 loopback sweep over every byte value
      wr(2'd1, 8'h0B);
      for (int v = 0; v < 256; v++) begin
         f0 = falls;
         xfer(v[7:0], got);
         chk("R2 loopback byte", got, v);
         chk("R2 eight clocks", falls - f0, 8);
         if (v % 32 == 0) begin rd(2'd2, d); chk("R3 full cleared", d[1], 0); end
      end

      // R4 flag lag over every divider phase
      for (int ph = 0; ph < 2 * HALF; ph++) begin
         repeat (ph) @(negedge clk);
         wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hC3;
         @(negedge clk); wr_en = 1'b0;
         rd_addr = 2'd2; c = 1;
         while (rd_data[0] !== 1'b0 && c < 40) begin @(negedge clk); c++; end
         chk("R4 lag in range", (c >= HALF && c <= 3 * HALF + 1), 1);
         wait_done(1'b1, 400, c);
         rd(2'd0, got); chk("R4 byte", got, 8'hC3);
      end

      // R5 back-to-back join
      f0 = falls;
      wr(2'd0, 8'h11);
      wait_done(1'b0, 40, c);
      wr(2'd0, 8'h22);
      wait_done(1'b1, 600, c);
      chk("R5 sixteen clocks before flag", falls - f0, 16);
      f0 = falls;
      repeat (20) @(negedge clk);
      chk("R5 clock idles", falls - f0, 0); chk("R5 sclk high", sclk_o, 1);
      rd(2'd0, got); chk("R5 last byte", got, 8'h22);

      // R3 receive disabled leaves buffer alone
      wr(2'd1, 8'h09);
      xfer(8'h77, got);
      chk("R3 buffer kept", got, 8'h22);
      rd(2'd2, d); chk("R3 no full", d[1], 0);

      // R6 no clock without transmit enable
      wr(2'd1, 8'h0A);
      f0 = falls;
      wr(2'd0, 8'h5E);
      repeat (40) @(negedge clk);
      chk("R6 no clock", falls - f0, 0);
      rd(2'd2, d); chk("R6 pending idle", d, 8'h05);
      wr(2'd1, 8'h0B);
      wait_done(1'b0, 40, c); wait_done(1'b1, 400, c);
      rd(2'd0, got); chk("R6 byte after enable", got, 8'h5E);

      // R7 transmit enable cleared mid-transfer
      f0 = falls;
      wr(2'd0, 8'hB4);
      wait_done(1'b0, 40, c);
      repeat (10) @(negedge clk);
      wr(2'd1, 8'h0A);
      wait_done(1'b1, 400, c);
      chk("R7 finished eight clocks", falls - f0, 8);
      rd(2'd0, got); chk("R7 byte", got, 8'hB4);
      wr(2'd1, 8'h0B);

      // R8 port enable cleared mid-transfer
      loop = 1'b0; b_rxd = 1'b0;
      wr(2'd0, 8'h5A);
      wait_done(1'b0, 40, c);
      wr(2'd1, 8'h03);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (k == 3 || k == 11) begin
            chk("R8 sclk parked", sclk_o, 1); chk("R8 txd parked", txd_o, 1);
         end
      end
      wr(2'd1, 8'h0B);
      wait_done(1'b1, 400, c);
      rd(2'd2, d); chk("R8 full", d[1], 1);
      rd(2'd0, got); chk("R8 byte", got, 8'h00);
      loop = 1'b1;

      // R9 clearing both enables resets
      wr(2'd0, 8'hA5);
      wait_done(1'b0, 40, c);
      repeat (20) @(negedge clk);
      wr(2'd1, 8'h08);
      @(negedge clk);
      chk("R9 sclk", sclk_o, 1); chk("R9 txd", txd_o, 1);
      rd(2'd2, d); chk("R9 status", d, 8'h01);
      f0 = falls;
      repeat (30) @(negedge clk);
      chk("R9 clock stopped", falls - f0, 0);
      wr(2'd1, 8'h0B);
      xfer(8'h3C, got); chk("R9 clean restart", got, 8'h3C);

      // R10/R11 external clock slave
      loop = 1'b0; sclk_i = 1'b1;
      wr(2'd1, 8'h1F);
      @(negedge clk); chk("R10 no byte", srdy_o, 0);
      wr(2'd0, 8'h96);
      chk("R10 ready", srdy_o, 1);
      wr(2'd1, 8'h1B); chk("R10 ready gated off", srdy_o, 0);
      wr(2'd1, 8'h1E); chk("R10 needs tx enable", srdy_o, 0);
      wr(2'd1, 8'h1F); chk("R10 ready again", srdy_o, 1);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         sclk_i = 1'b0;
         repeat (8) @(negedge clk);
         if (i == 0) chk("R10 ready drops", srdy_o, 0);
         chk("R11 ext txd bit", txd_o, (8'h96 >> i) & 1);
         b_rxd = (8'h4D >> i) & 1;
         sclk_i = 1'b1;
         repeat (8) @(negedge clk);
      end
      rd(2'd2, d); chk("R11 status", d, 8'h03);
      rd(2'd0, got); chk("R11 ext byte", got, 8'h4D);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule